// File: doc/BRIEF.md
# Sync-Triggered Start and Hop Controller

This block sits beside one receive channel and decides when that channel wakes up and when its oscillator changes frequency. Both actions follow a synchronization event. Software can raise the event through a register write. A sync pin can also raise it, but only for a path that has been both enabled and selected for the pin. Each action has its own 16-bit hold-off counter. The event loads the counter with a programmed delay. When the counter expires, the channel leaves sleep (start path) or the active 32-bit frequency word takes the value of two staged 16-bit halves (hop path).

Software writes the hold-off values, the staged frequency halves and the routing bits through a small write-only register port. A hold-off of 1 gives the shortest delay and a hold-off of 0 turns the response off. A first-sync-only mode lets only the first pin pulse act. A hop can keep the oscillator phase, or it can clear the phase accumulator through a one-cycle pulse.

Top module: `sync_start_hop_ctrl`

## Requirements
- R1: While reset is applied and right after it, `sleep` is 1, `freq_word` is 0 and `acc_clear` is 0.
- R2: A start sync with a start hold-off v of 1 or more drives `sleep` low on the v-th rising clock edge after the edge that samples the sync. `sleep` then stays low until reset.
- R3: A hop sync with a hop hold-off v of 1 or more loads `freq_word` with {staged high half, staged low half} on the v-th rising edge after the sampling edge.
- R4: A hold-off of 1 acts on the first clock edge after the sync is sampled.
- R5: A sync sampled while the hold-off is 0 causes no start or hop. If that counter is already counting, the countdown is cancelled.
- R6: A rising edge on `sync_pin` acts as a start sync only if both the pin-start enable (control bit 0) and the pin-start select (bit 2) are set. It acts as a hop sync only if both the pin-hop enable (bit 1) and the pin-hop select (bit 3) are set.
- R7: While first-sync-only (control bit 4) is set, only the first routed pin edge acts and later pin edges are ignored. Software syncs are never blocked.
- R8: Writing the control register with bit 4 low clears the first-sync-only memory, so the next routed pin edge acts again once bit 4 is set again.
- R9: A sync that arrives while a counter is running reloads the counter, and the delay is measured again from the new sync.
- R10: Writes to the staged halves (address 4 low, address 5 high) leave `freq_word` unchanged until a hop expires.
- R11: When control bit 5 (phase-continuous hop) is 0, `acc_clear` is 1 for exactly the one cycle in which the new `freq_word` first appears. When bit 5 is 1, `acc_clear` stays 0.
- R12: Register map: address 0 is the software sync (bit 0 requests a start, bit 1 requests a hop), address 1 is control, address 2 is the start hold-off and address 3 is the hop hold-off. A software sync is taken on the write itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_pin | input | 1 | External sync, synchronous to clk, acts on its rising edge |
| sleep | output | 1 | Channel sleep state, 1 = sleeping |
| freq_word | output | 32 | Active oscillator frequency word |
| acc_clear | output | 1 | One-cycle request to clear the oscillator phase accumulator |

## Verification
The assertions assume that `sync_pin` is already synchronous to `clk` and changes only between edges. They also assume that register writes are single-cycle strobes whose address selects one defined register. The bench drives every input on the falling edge, keeps each write strobe to one cycle, and raises the pin for exactly one cycle. The assertions also assume that the control register changes only through writes. The bench therefore rewrites control only while both counters are idle, so that no expiry is lost to a routing change in the middle of a countdown.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned HALF_W = FREQ_W / 2;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SOFT       = 3'd0,
    A_CTRL       = 3'd1,
    A_START_HOLD = 3'd2,
    A_HOP_HOLD   = 3'd3,
    A_STAGE_LO   = 3'd4,
    A_STAGE_HI   = 3'd5
  } reg_addr_e;

  // control register, bit 5 down to bit 0
  typedef struct packed {
    logic hop_cont;
    logic first_only;
    logic hop_sel;
    logic start_sel;
    logic hop_en;
    logic start_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // counter step: idle (zero) stays idle
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return (c != '0) ? c - CNT_W'(1) : '0;
  endfunction

  // a countdown expires on the cycle it holds one
  function automatic logic cnt_expired(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction
endpackage

// File: rtl/ssh_ctrl_regs.sv
module ssh_ctrl_regs
  import ssh_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [HALF_W-1:0]        wr_data,
  output ctrl_t                    ctrl,
  output logic [CNT_W-1:0]         start_hold,
  output logic [CNT_W-1:0]         hop_hold,
  output logic [FREQ_W-1:0]        staged_word,
  output logic                     soft_start,
  output logic                     soft_hop
);
  logic [HALF_W-1:0] stage_lo_q, stage_hi_q;
  logic              sel_soft;

  assign sel_soft    = wr_en && (wr_addr == A_SOFT);
  assign soft_start  = sel_soft && wr_data[0];
  assign soft_hop    = sel_soft && wr_data[1];
  assign staged_word = {stage_hi_q, stage_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      start_hold <= '0;
      hop_hold   <= '0;
      stage_lo_q <= '0;
      stage_hi_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:       ctrl       <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_START_HOLD: start_hold <= wr_data[CNT_W-1:0];
        A_HOP_HOLD:   hop_hold   <= wr_data[CNT_W-1:0];
        A_STAGE_LO:   stage_lo_q <= wr_data;
        A_STAGE_HI:   stage_hi_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ssh_sync_router.sv
module ssh_sync_router (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pin,
  input  logic start_en,
  input  logic start_sel,
  input  logic hop_en,
  input  logic hop_sel,
  input  logic first_only,
  output logic pin_start,
  output logic pin_hop,
  output logic seen
);
  logic pin_q, pin_edge, route_start, route_hop, allow;

  assign pin_edge    = sync_pin && !pin_q;
  assign route_start = start_en && start_sel;
  assign route_hop   = hop_en && hop_sel;
  assign allow       = !(first_only && seen);
  assign pin_start   = pin_edge && route_start && allow;
  assign pin_hop     = pin_edge && route_hop && allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      seen  <= 1'b0;
    end else begin
      pin_q <= sync_pin;
      seen  <= first_only ? (seen || (pin_edge && (route_start || route_hop))) : 1'b0;
    end
  end
endmodule

// File: rtl/ssh_holdoff_counter.sv
module ssh_holdoff_counter
  import ssh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             fire
);
  assign fire = cnt_expired(count);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else           count <= cnt_next(count);
  end
endmodule

// File: rtl/sync_start_hop_ctrl.sv
module sync_start_hop_ctrl
  import ssh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [HALF_W-1:0]   wr_data,
  input  logic                sync_pin,
  output logic                sleep,
  output logic [FREQ_W-1:0]   freq_word,
  output logic                acc_clear
);
  localparam int unsigned NPATH = 2; // 0 = start, 1 = hop

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  start_hold, hop_hold;
  logic [FREQ_W-1:0] staged_word;
  logic              soft_start, soft_hop, pin_start, pin_hop, seen;

  logic [NPATH-1:0]  trig, fire;
  logic [CNT_W-1:0]  hold [NPATH];
  logic [CNT_W-1:0]  cnt  [NPATH];

  // named events for the checker
  logic             start_trig, hop_trig, start_fire, hop_fire;
  logic [CNT_W-1:0] start_cnt;

  ssh_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .start_hold(start_hold), .hop_hold(hop_hold),
    .staged_word(staged_word), .soft_start(soft_start), .soft_hop(soft_hop)
  );

  ssh_sync_router u_router (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin),
    .start_en(ctrl.start_en), .start_sel(ctrl.start_sel),
    .hop_en(ctrl.hop_en), .hop_sel(ctrl.hop_sel), .first_only(ctrl.first_only),
    .pin_start(pin_start), .pin_hop(pin_hop), .seen(seen)
  );

  assign trig[0] = soft_start || pin_start;
  assign trig[1] = soft_hop || pin_hop;
  assign hold[0] = start_hold;
  assign hold[1] = hop_hold;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    ssh_holdoff_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .load(trig[g]), .load_val(hold[g]),
      .count(cnt[g]), .fire(fire[g])
    );
  end

  assign start_trig = trig[0];
  assign hop_trig   = trig[1];
  assign start_fire = fire[0];
  assign hop_fire   = fire[1];
  assign start_cnt  = cnt[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep     <= 1'b1;
      freq_word <= '0;
      acc_clear <= 1'b0;
    end else begin
      if (start_fire) sleep <= 1'b0;
      if (hop_fire)   freq_word <= staged_word;
      acc_clear <= hop_fire && !ctrl.hop_cont;
    end
  end
endmodule

// File: rtl/ssh_checker.sv
module ssh_checker
  import ssh_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic [FREQ_W-1:0] freq_word,
  input logic              acc_clear,
  input logic [FREQ_W-1:0] staged_word,
  input logic              start_trig,
  input logic              start_fire,
  input logic              hop_fire,
  input logic [CNT_W-1:0]  start_hold,
  input logic [CNT_W-1:0]  start_cnt,
  input logic              hop_cont,
  input logic              first_only,
  input logic              seen,
  input logic              pin_start,
  input logic              pin_hop
);
  p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n) start_fire |=> !sleep);
  p_stay_awake_r2: assert property (@(posedge clk) disable iff (!rst_n) !sleep |=> !sleep);
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cnt > CNT_W'(1) && !start_trig) |=> start_cnt == $past(start_cnt) - CNT_W'(1));
  p_hop_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hop_fire |=> freq_word == $past(staged_word));
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_trig && start_hold == '0) |=> start_cnt == '0);
  p_first_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (first_only && seen) |-> !(pin_start || pin_hop));
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_trig |=> start_cnt == $past(start_hold));
  p_freq_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_fire |=> $stable(freq_word));
  p_acc_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |-> $past(hop_fire && !hop_cont));
endmodule

bind sync_start_hop_ctrl ssh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(sleep), .freq_word(freq_word),
  .acc_clear(acc_clear), .staged_word(staged_word), .start_trig(start_trig),
  .start_fire(start_fire), .hop_fire(hop_fire), .start_hold(start_hold),
  .start_cnt(start_cnt), .hop_cont(ctrl.hop_cont), .first_only(ctrl.first_only),
  .seen(seen), .pin_start(pin_start), .pin_hop(pin_hop)
);

// File: tb/test_sync_start_hop_ctrl.sv
`timescale 1ns/1ps
module test_sync_start_hop_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_pin = 1'b0;
  logic        sleep;
  logic [31:0] freq_word;
  logic        acc_clear;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_start_hop_ctrl i_sync_start_hop_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_pin(sync_pin), .sleep(sleep), .freq_word(freq_word), .acc_clear(acc_clear)
  );

  // {pin trigger, hop path, hold-off}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 1'b0, 16'd1}, {1'b0, 1'b0, 16'd2}, {1'b0, 1'b0, 16'd9},
    {1'b1, 1'b0, 16'd3}, {1'b0, 1'b1, 16'd4}, {1'b1, 1'b1, 16'd1}
  };
  localparam int LIM = 40;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_pin();
    @(negedge clk); sync_pin = 1'b1;
    @(negedge clk); sync_pin = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wake(output int n);
    n = 0;
    for (int i = 1; i <= LIM; i++) begin
      @(negedge clk);
      if (!sleep && n == 0) n = i;
    end
  endtask

  task automatic wait_hop(input logic [31:0] old, output int n, output logic acc,
                          output logic acc_after);
    n = 0; acc = 1'b0; acc_after = 1'b0;
    for (int i = 1; i <= LIM; i++) begin
      @(negedge clk);
      if (n == i - 1 && n != 0) acc_after = acc_clear;
      if (freq_word != old && n == 0) begin n = i; acc = acc_clear; end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lat;
    logic a0, a1;
    logic [31:0] expw;

    // R1 reset state
    do_reset();
    chk("R1 sleep", sleep, 1);
    chk("R1 freq", freq_word, 0);
    chk("R1 acc_clear", acc_clear, 0);

    // table walk: R2 R3 R4 R6 R12
    for (int k = 0; k < 6; k++) begin
      logic is_pin, is_hop;
      logic [15:0] v;
      is_pin = VEC[k][17]; is_hop = VEC[k][16]; v = VEC[k][15:0];
      do_reset();
      wr(3'd1, 16'h002F);
      wr(is_hop ? 3'd3 : 3'd2, v);
      wr(3'd4, 16'h1000 + 16'(k));
      wr(3'd5, 16'hA000 + 16'(k));
      expw = {16'hA000 + 16'(k), 16'h1000 + 16'(k)};
      if (is_pin) pulse_pin(); else wr(3'd0, is_hop ? 16'h2 : 16'h1);
      if (is_hop) begin
        wait_hop(32'h0, lat, a0, a1);
        chk(v == 1 ? "R4 hop latency" : "R3 hop latency", lat, v);
        chk("R3 hop word", freq_word, expw);
        chk("R11 continuous no clear", a0, 0);
      end else begin
        wait_wake(lat);
        chk(v == 1 ? "R4 start latency" : "R2 start latency", lat, v);
        chk("R2 stays awake", sleep, 0);
      end
    end

    // R5 zero hold-off, and cancel of a running count
    do_reset();
    wr(3'd0, 16'h1);
    wait_wake(lat);
    chk("R5 zero hold no start", lat, 0);
    wr(3'd2, 16'd8);
    wr(3'd0, 16'h1);
    idle(2);
    wr(3'd2, 16'd0);
    wr(3'd0, 16'h1);
    wait_wake(lat);
    chk("R5 zero cancels count", lat, 0);

    // R6 enable without select, select without enable
    do_reset();
    wr(3'd2, 16'd1);
    wr(3'd1, 16'h0001);
    pulse_pin();
    wait_wake(lat);
    chk("R6 enable only", lat, 0);
    wr(3'd1, 16'h0004);
    pulse_pin();
    wait_wake(lat);
    chk("R6 select only", lat, 0);
    wr(3'd1, 16'h0005);
    pulse_pin();
    wait_wake(lat);
    chk("R6 enable and select", lat, 1);

    // R10 staged writes do not reach the active word
    do_reset();
    wr(3'd4, 16'h5555);
    wr(3'd5, 16'h6666);
    idle(5);
    chk("R10 staged isolated", freq_word, 0);

    // R7 / R8 first-sync-only on the hop path
    wr(3'd3, 16'd1);
    wr(3'd1, 16'h003A);
    pulse_pin();
    wait_hop(32'h0, lat, a0, a1);
    chk("R7 first pin acts", freq_word, 32'h6666_5555);
    wr(3'd4, 16'h7777);
    wr(3'd5, 16'h8888);
    pulse_pin();
    idle(5);
    chk("R7 later pin ignored", freq_word, 32'h6666_5555);
    wr(3'd0, 16'h2);
    idle(3);
    chk("R7 soft sync not blocked", freq_word, 32'h8888_7777);
    wr(3'd4, 16'h9999);
    wr(3'd1, 16'h002A);
    wr(3'd1, 16'h003A);
    pulse_pin();
    idle(3);
    chk("R8 latch cleared", freq_word, 32'h8888_9999);

    // R9 reload during countdown
    do_reset();
    wr(3'd2, 16'd10);
    wr(3'd0, 16'h1);
    idle(4);
    wr(3'd0, 16'h1);
    wait_wake(lat);
    chk("R9 reload latency", lat, 10);

    // R11 phase-clearing hop then phase-continuous hop
    do_reset();
    wr(3'd3, 16'd3);
    wr(3'd4, 16'h0101);
    wr(3'd5, 16'h0202);
    wr(3'd0, 16'h2);
    wait_hop(32'h0, lat, a0, a1);
    chk("R11 latency", lat, 3);
    chk("R11 clear with new word", a0, 1);
    chk("R11 clear one cycle", a1, 0);
    wr(3'd1, 16'h0020);
    wr(3'd4, 16'h0303);
    wr(3'd0, 16'h2);
    wait_hop(32'h0202_0101, lat, a0, a1);
    chk("R11 continuous hop", freq_word, 32'h0202_0303);
    chk("R11 continuous no clear", a0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule